// File: doc/BRIEF.md
# Event Packet Framer with Integrity Fields

This block sits between a detector card's hit-word source and the storage path. It gathers the zero-suppressed hit words of one event. The number of words changes from event to event. The block then sends them on as a self-describing packet, so that a reader of the stored stream can check each event and recover from damage.

A packet is made of a start word, three header words, the payload, a CRC word and an end word. The header words carry the firmware version with the card identifier, the card's trigger number, and the payload word count with an overflow bit. The CRC lets a reader detect corrupted or missing bits. The trigger number lets a reader regroup packets that reach the host out of order. The end word gives the reader a point to resynchronise on after an error.

The input and output are valid/ready word streams. The input has an end-of-event flag. The block holds at most one event. It does not accept new words while a packet is being sent.

Top module: `evt_packet_framer`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A packet starts with START_WORD (default 16'hA5C3). The next word is {FW_VERSION, CARD_ID}, with the version in the upper half and the card identifier in the lower half.
- R3: The third packet word is the trigger number. It is 0 for the first packet after reset and rises by one for each packet that is sent.
- R4: The fourth packet word holds the number of payload words sent, in bits [14:0]. Bit 15 is the overflow flag.
- R5: The payload words follow the header in the order in which they were accepted.
- R6: An event with more than DEPTH words (default 256) is cut to its first DEPTH words. The extra words are accepted and dropped, the count reads DEPTH, and the overflow flag is 1. An event of exactly DEPTH words has the overflow flag at 0.
- R7: After the payload comes a CRC-16 word. The polynomial is 0x1021 and the initial value is 0xFFFF. The CRC is computed most significant bit first over the three header words and the payload words, not over the start word.
- R8: The last word of every packet is END_WORD (default 16'h5A3C).
- R9: in_ready is 0 from the cycle after the end-of-event word is accepted until the end word has been taken. While it is 0, out_valid is 1. In the cycle after the end word is taken, in_ready is 1 again.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_data | input | DATA_W | Payload hit word |
| in_last | input | 1 | Marks the last word of the event |
| out_valid | output | 1 | Packet word valid |
| out_ready | input | 1 | Downstream takes the packet word |
| out_data | output | DATA_W | Packet word |

## Verification
Two functions can fall in the same cycle: deciding whether a word overflows the buffer, and closing the event on its end-of-event flag. The bench provokes this with events of exactly DEPTH words and of DEPTH+1 words. In the second case the word carrying the flag must be dropped, must still end the event, and must set the overflow bit. In the first case the last word must be kept, with no overflow bit. A reference model built from queues predicts every packet word. Each word taken is compared with the model while out_ready is toggled at random, which also exercises stalls on the CRC and end words.

// File: rtl/evt_framer_pkg.sv
package evt_framer_pkg;
   typedef enum logic [0:0] {
      ST_COLLECT = 1'b0,
      ST_EMIT    = 1'b1
   } frm_state_e;

   // fixed word slots at the head of every packet
   localparam int SLOT_START = 0;
   localparam int SLOT_ID    = 1;
   localparam int SLOT_TRIG  = 2;
   localparam int SLOT_COUNT = 3;
   localparam int HEAD_WORDS = 4;
   localparam int TAIL_WORDS = 2;
endpackage

// File: rtl/evt_payload_buf.sv
module evt_payload_buf #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 256,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count,
   output logic              ovf
);
   localparam int ADDR_W = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic              full;

   assign full    = (count == CNT_W'(DEPTH));
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (wr_en && !full) mem[count[ADDR_W-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (wr_en) begin
         if (full) ovf   <= 1'b1;
         else      count <= count + 1'b1;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R6
   AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> full); // R6
endmodule

// File: rtl/evt_crc16.sv
module evt_crc16 #(
   parameter int          DATA_W = 16,
   parameter logic [15:0] POLY   = 16'h1021,
   parameter logic [15:0] INIT   = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              en,
   input  logic [DATA_W-1:0] data,
   output logic [15:0]       crc
);
   logic [15:0] chain [DATA_W+1];

   assign chain[0] = crc;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      logic fb;
      assign fb           = chain[g][15] ^ data[DATA_W-1-g];
      assign chain[g + 1] = {chain[g][14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || init) crc <= INIT;
      else if (en)        crc <= chain[DATA_W];
   end
endmodule

// File: rtl/evt_packet_framer.sv
module evt_packet_framer
   import evt_framer_pkg::*;
#(
   parameter int                      DATA_W     = 16,
   parameter int                      DEPTH      = 256,
   parameter logic [DATA_W-1:0]       START_WORD = 16'hA5C3,
   parameter logic [DATA_W-1:0]       END_WORD   = 16'h5A3C,
   parameter logic [DATA_W/2-1:0]     FW_VERSION = 8'h13,
   parameter logic [DATA_W/2-1:0]     CARD_ID    = 8'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int IDX_W  = $clog2(DEPTH + HEAD_WORDS + TAIL_WORDS);
   localparam int PAD_W  = DATA_W - 1 - CNT_W;

   if (DATA_W < 16 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("DATA_W must be even and at least 16");
   end
   if (DEPTH < 2 || PAD_W < 0) begin : g_bad_depth
      $error("DEPTH must fit the count field of the header");
   end

   frm_state_e        state;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] trig;
   logic [CNT_W-1:0]  count;
   logic              ovf;
   logic [DATA_W-1:0] rd_data;
   logic [15:0]       crc;
   logic              in_fire, out_fire;
   logic [IDX_W-1:0]  crc_idx, end_idx;
   logic              at_end, in_crc_span;
   logic [DATA_W-1:0] count_word;

   assign in_ready  = (state == ST_COLLECT);
   assign out_valid = (state == ST_EMIT);
   assign in_fire   = in_valid && in_ready;
   assign out_fire  = out_valid && out_ready;

   assign crc_idx     = IDX_W'(count) + IDX_W'(HEAD_WORDS);
   assign end_idx     = crc_idx + 1'b1;
   assign at_end      = (idx == end_idx);
   assign in_crc_span = (idx >= IDX_W'(SLOT_ID)) && (idx < crc_idx);

   if (PAD_W > 0) begin : g_pad
      assign count_word = {ovf, {PAD_W{1'b0}}, count};
   end else begin : g_nopad
      assign count_word = {ovf, count};
   end

   evt_payload_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (out_fire && at_end),
      .wr_en   (in_fire),
      .wr_data (in_data),
      .rd_addr (ADDR_W'(idx - IDX_W'(HEAD_WORDS))),
      .rd_data (rd_data),
      .count   (count),
      .ovf     (ovf)
   );

   evt_crc16 #(.DATA_W(DATA_W)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (out_fire && at_end),
      .en    (out_fire && in_crc_span),
      .data  (out_data),
      .crc   (crc)
   );

   always_comb begin
      if (idx == IDX_W'(SLOT_START))      out_data = START_WORD;
      else if (idx == IDX_W'(SLOT_ID))    out_data = {FW_VERSION, CARD_ID};
      else if (idx == IDX_W'(SLOT_TRIG))  out_data = trig;
      else if (idx == IDX_W'(SLOT_COUNT)) out_data = count_word;
      else if (idx == crc_idx)            out_data = DATA_W'(crc);
      else if (at_end)                    out_data = END_WORD;
      else                                out_data = rd_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_COLLECT;
         idx   <= '0;
         trig  <= '0;
      end else begin
         case (state)
            ST_COLLECT: begin
               idx <= '0;
               if (in_fire && in_last) state <= ST_EMIT;
            end
            ST_EMIT: begin
               if (out_fire) begin
                  if (at_end) begin
                     state <= ST_COLLECT;
                     trig  <= trig + 1'b1;
                     idx   <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            default: state <= ST_COLLECT;
         endcase
      end
   end

   AST_START_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fire && in_last) |=> (out_valid && out_data == START_WORD)); // R2
   AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
   AST_TRIG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && at_end) |=> (trig == $past(trig) + 1'b1)); // R3
   AST_READY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && at_end) |=> (in_ready && !out_valid)); // R9
   AST_END_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && $past(out_fire) && $past(out_data) == DATA_W'(crc) && at_end)
      |-> (out_data == END_WORD)); // R8
endmodule

// File: tb/evt_packet_framer_tb.sv
module evt_packet_framer_tb;
   localparam int          DW    = 16;
   localparam int          DEPTH = 256;
   localparam logic [15:0] SW    = 16'hA5C3;
   localparam logic [15:0] EW    = 16'h5A3C;
   localparam logic [15:0] IDW   = 16'h1302;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_ready, out_valid;
   logic [DW-1:0] out_data;

   int            n_tests = 0, n_fail = 0;
   int            ready_pct = 100;
   int            trig_model = 0;
   logic [15:0]   exp_q[$];
   string         tag_q[$];
   logic          prev_stall = 1'b0;
   logic [DW-1:0] prev_data = '0;

   always #10 clk = ~clk;

   evt_packet_framer u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   function automatic logic [15:0] crc_word(logic [15:0] c, logic [15:0] w);
      logic [15:0] r = c;
      for (int b = 15; b >= 0; b--) begin
         if (r[15] ^ w[b]) r = {r[14:0], 1'b0} ^ 16'h1021;
         else              r = {r[14:0], 1'b0};
      end
      return r;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(logic [15:0] w, string tag);
      exp_q.push_back(w);
      tag_q.push_back(tag);
   endtask

   // reference model of one packet plus the input driver
   task automatic send_event(int n, int gap_pct);
      logic [15:0] words[$];
      logic [15:0] c = 16'hFFFF;
      int          kept = (n > DEPTH) ? DEPTH : n;
      logic [15:0] cw;
      for (int i = 0; i < n; i++) words.push_back(16'($urandom));
      cw = {(n > DEPTH), 6'b0, 9'(kept)};
      push(SW, "R2 start");
      push(IDW, "R2 id");
      push(16'(trig_model), "R3 trig");
      push(cw, (n > DEPTH) ? "R6 count" : "R4 count");
      c = crc_word(c, IDW);
      c = crc_word(c, 16'(trig_model));
      c = crc_word(c, cw);
      for (int i = 0; i < kept; i++) begin
         push(words[i], (n >= DEPTH) ? "R6 payload" : "R5 payload");
         c = crc_word(c, words[i]);
      end
      push(c, "R7 crc");
      push(EW, "R8 end");
      trig_model++;
      for (int i = 0; i < n; i++) begin
         while (($urandom % 100) < gap_pct) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = words[i];
         in_last  = (i == n - 1);
         while (!in_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      check("R9 ready after packet", {out_valid, in_ready}, 2'b01);
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         out_ready = (($urandom % 100) < ready_pct);
         if (prev_stall) check("R10 stall hold", {out_valid, out_data}, {1'b1, prev_data});
         if (out_valid) check("R9 ready low while emitting", in_ready, 1'b0);
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check("R5 spurious word", out_data, 16'hxxxx);
            end else begin
               check(tag_q[0], out_data, exp_q[0]);
               void'(exp_q.pop_front());
               void'(tag_q.pop_front());
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      check("R1 reset in_ready/out_valid", {in_ready, out_valid}, 2'b10);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", {in_ready, out_valid}, 2'b10);

      ready_pct = 100;
      send_event(1, 0);
      send_event(5, 0);
      drain();
      ready_pct = 50;
      send_event(DEPTH, 10);     // exactly full: no overflow (R6)
      send_event(DEPTH + 1, 0);  // flagged word dropped, overflow (R6)
      drain();
      ready_pct = 25;
      send_event(DEPTH + 44, 30);
      for (int k = 0; k < 6; k++) send_event(1 + ($urandom % 40), 40);
      drain();
      ready_pct = 100;
      send_event(3, 0);
      drain();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule